// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar and raises a polled alarm flag when the current time matches a programmed alarm point. Seven alarm threshold registers each hold one calendar field: seconds, minutes, hours, date, month, day-of-week and year. One configuration register chooses which of these fields take part in the match. The comparison runs once per seconds tick. When every selected field equals its live counterpart, the flag sets and stays set.

Software never sees an interrupt. It polls the flag, which is returned as the top bit of the minutes register whenever that register is read. The flag clears as a side effect of any read or accepted write to the configuration register or to any threshold register. Accesses arrive as one-cycle strobes carrying an 8-bit command byte. Bit 7 of the command selects read (1) or write (0). Bit 6 must be 0 to select register space. Bits 5:1 give the register index. A write takes effect only if bit 0 is 1.

A three-state controller tracks the alarm. `IDLE` means the configuration is zero and the alarm is disarmed. `ARMED` means the alarm is watching for a match. `FIRED` means the flag is set. The transitions are:
- `IDLE->ARMED` when the configuration becomes nonzero.
- `ARMED->FIRED` on a tick with a full match and no alarm-register access in the same cycle.
- `ARMED->IDLE` and `FIRED->IDLE` when an access leaves the configuration zero.
- `FIRED->ARMED` when an alarm-register access leaves the configuration nonzero.

Top module: `alm_poll_top`

## Requirements
- R1: Command decode. Bit 7 = 1 is a read and bit 7 = 0 is a write. Bit 6 must be 0 to select register space. Bits 5:1 are the register index. A write with bit 0 = 0 has no effect at all: nothing is stored and the flag is not cleared.
- R2: The seven thresholds sit at indexes 12..18, in the order seconds, minutes, hours, date, month, day-of-week, year. Their write commands are 0x19, 0x1B, 0x1D, 0x1F, 0x21, 0x23, 0x25, and their read commands are the same values with bit 7 set. A read returns the stored byte.
- R3: The configuration register is written with command 0x15 and read with 0x95. Bits 0..6 enable seconds, minutes, hours, date, month, day-of-week and year respectively. Bit 7 always reads 0.
- R4: When `tick_i` is high, the flag is set at the next clock edge if every enabled field of `live_i` equals its threshold byte in full, including the hours mode and PM bits. `live_i` carries seconds in bits 7:0 and year in bits 55:48.
- R5: A configuration value of zero never sets the flag.
- R6: The flag never sets in a cycle without `tick_i`, even if the fields match.
- R7: Once set, the flag stays set across later ticks, including ticks with mismatching fields, and across reads of other registers.
- R8: A read, or an accepted write, of the configuration register or of any threshold register clears the flag at the next edge. Such an access wins over a match in the same cycle.
- R9: A read with command 0x83 (minutes, index 1) returns the flag in bit 7 and minutes bits 6:0 of `live_i` in bits 6:0.
- R10: After reset the flag, the configuration and all thresholds are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse; `live_i` holds the new second in this cycle |
| live_i | input | 56 | Live calendar fields, seconds in the low byte, year in the high byte |
| acc_en_i | input | 1 | Register access strobe, one cycle |
| acc_cmd_i | input | 8 | Command byte |
| acc_wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while the strobe is high with a read command |
| flag_o | output | 1 | Alarm flag |

## Verification
The assertions check the controller's rules on every cycle:
- a zero configuration is never seen together with a set flag;
- the flag rises only in a cycle after a tick;
- the flag holds while there is no alarm-register access;
- an alarm access clears it;
- a tick with a full match and no access sets it.

Only the bench scenarios can show the rest. These cover the field-by-field masking under different enable patterns and the full-byte hours compare. They also cover the command decode, including the discarded write with bit 0 clear, the read-back of bit 7 as zero and the merged minutes read value.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NF        = 7;
    localparam int FW        = 8;
    localparam int IDX_W     = 5;
    localparam int IDX_MIN   = 1;
    localparam int IDX_CFG   = 10;
    localparam int IDX_THR0  = 12;
    localparam int LIVE_W    = NF * FW;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_FIRED = 2'd2
    } alm_state_e;
endpackage

// File: rtl/alm_decode.sv
module alm_decode #(
    parameter int NF       = 7,
    parameter int IDX_W    = 5,
    parameter int IDX_CFG  = 10,
    parameter int IDX_THR0 = 12,
    parameter int IDX_MIN  = 1
) (
    input  logic          acc_en_i,
    input  logic [7:0]    cmd_i,
    output logic          is_rd_o,
    output logic          cfg_sel_o,
    output logic [NF-1:0] thr_sel_o,
    output logic          min_sel_o,
    output logic          cfg_we_o,
    output logic [NF-1:0] thr_we_o,
    output logic          alm_acc_o
);
    logic             reg_space;
    logic             wr_ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        is_rd_o   = cmd_i[7];
        reg_space = !cmd_i[6];
        idx       = cmd_i[IDX_W:1];
        wr_ok     = !cmd_i[7] && cmd_i[0];
        cfg_sel_o = reg_space && (idx == IDX_W'(IDX_CFG));
        min_sel_o = reg_space && (idx == IDX_W'(IDX_MIN));
    end

    for (genvar k = 0; k < NF; k++) begin : g_sel
        assign thr_sel_o[k] = reg_space && (idx == IDX_W'(IDX_THR0 + k));
        assign thr_we_o[k]  = acc_en_i && thr_sel_o[k] && wr_ok;
    end

    assign cfg_we_o  = acc_en_i && cfg_sel_o && wr_ok;
    assign alm_acc_o = acc_en_i && (cfg_sel_o || (|thr_sel_o)) && (is_rd_o || wr_ok);
endmodule

// File: rtl/alm_regs.sv
module alm_regs #(
    parameter int NF = 7,
    parameter int FW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [NF-1:0]    thr_we_i,
    input  logic [FW-1:0]    wdata_i,
    output logic [NF-1:0]    cfg_q_o,
    output logic [NF-1:0]    cfg_d_o,
    output logic [NF*FW-1:0] thr_q_o
);
    logic [NF-1:0] cfg_q;

    always_comb begin
        cfg_d_o = cfg_we_i ? wdata_i[NF-1:0] : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d_o;
        end
    end

    for (genvar k = 0; k < NF; k++) begin : g_thr
        logic [FW-1:0] thr_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q <= '0;
            end else if (thr_we_i[k]) begin
                thr_q <= wdata_i;
            end
        end
        assign thr_q_o[k*FW +: FW] = thr_q;
    end

    assign cfg_q_o = cfg_q;
endmodule

// File: rtl/alm_match.sv
module alm_match #(
    parameter int NF = 7,
    parameter int FW = 8
) (
    input  logic [NF-1:0]    mask_i,
    input  logic [NF*FW-1:0] live_i,
    input  logic [NF*FW-1:0] thr_i,
    output logic             hit_o
);
    logic [NF-1:0] eq;

    for (genvar k = 0; k < NF; k++) begin : g_cmp
        assign eq[k] = !mask_i[k] || (live_i[k*FW +: FW] == thr_i[k*FW +: FW]);
    end

    assign hit_o = &eq;
endmodule

// File: rtl/alm_fsm.sv
module alm_fsm
    import alm_pkg::*;
#(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          hit_i,
    input  logic          alm_acc_i,
    input  logic [NF-1:0] cfg_q_i,
    input  logic [NF-1:0] cfg_d_i,
    output logic          flag_o
);
    alm_state_e state_q, state_d;
    logic       cfg_next_nz;

    assign cfg_next_nz = |cfg_d_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cfg_next_nz) state_d = S_ARMED;
            end
            S_ARMED: begin
                if (!cfg_next_nz)              state_d = S_IDLE;
                else if (alm_acc_i)            state_d = S_ARMED;
                else if (tick_i && hit_i)      state_d = S_FIRED;
            end
            S_FIRED: begin
                if (alm_acc_i) state_d = cfg_next_nz ? S_ARMED : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == S_FIRED);
    end

    a_r5_zero_cfg_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q_i == '0) |-> !flag_o);

    a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !alm_acc_i) |=> flag_o);

    a_r8_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        alm_acc_i |=> !flag_o);

    a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i && !alm_acc_i && (cfg_q_i != '0)) |=> flag_o);
endmodule

// File: rtl/alm_poll_top.sv
module alm_poll_top
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [LIVE_W-1:0] live_i,
    input  logic              acc_en_i,
    input  logic [7:0]        acc_cmd_i,
    input  logic [7:0]        acc_wdata_i,
    output logic [7:0]        rdata_o,
    output logic              flag_o
);
    logic          is_rd, cfg_sel, min_sel, cfg_we, alm_acc, hit;
    logic [NF-1:0] thr_sel, thr_we, cfg_q, cfg_d;
    logic [LIVE_W-1:0] thr_q;

    alm_decode #(.NF(NF), .IDX_W(IDX_W), .IDX_CFG(IDX_CFG),
                 .IDX_THR0(IDX_THR0), .IDX_MIN(IDX_MIN)) u_dec (
        .acc_en_i (acc_en_i),
        .cmd_i    (acc_cmd_i),
        .is_rd_o  (is_rd),
        .cfg_sel_o(cfg_sel),
        .thr_sel_o(thr_sel),
        .min_sel_o(min_sel),
        .cfg_we_o (cfg_we),
        .thr_we_o (thr_we),
        .alm_acc_o(alm_acc)
    );

    alm_regs #(.NF(NF), .FW(FW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we_i(cfg_we),
        .thr_we_i(thr_we),
        .wdata_i (acc_wdata_i),
        .cfg_q_o (cfg_q),
        .cfg_d_o (cfg_d),
        .thr_q_o (thr_q)
    );

    alm_match #(.NF(NF), .FW(FW)) u_match (
        .mask_i(cfg_q),
        .live_i(live_i),
        .thr_i (thr_q),
        .hit_o (hit)
    );

    alm_fsm #(.NF(NF)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .hit_i    (hit),
        .alm_acc_i(alm_acc),
        .cfg_q_i  (cfg_q),
        .cfg_d_i  (cfg_d),
        .flag_o   (flag_o)
    );

    always_comb begin
        rdata_o = '0;
        if (acc_en_i && is_rd) begin
            if (cfg_sel) begin
                rdata_o = 8'(cfg_q);
            end else if (min_sel) begin
                rdata_o = {flag_o, live_i[FW + 6 : FW]};
            end else begin
                for (int k = 0; k < NF; k++) begin
                    if (thr_sel[k]) rdata_o = thr_q[k*FW +: FW];
                end
            end
        end
    end
endmodule

// File: tb/sim_alm_poll_top.sv
module sim_alm_poll_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [55:0] live = '0;
    logic        acc_en = 1'b0;
    logic [7:0]  cmd = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alm_poll_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .live_i(live),
        .acc_en_i(acc_en), .acc_cmd_i(cmd), .acc_wdata_i(wdata),
        .rdata_o(rdata), .flag_o(flag)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [55:0] lv;
        logic        exp;
    } vec_t;

    localparam logic [55:0] LM = 56'h02050704B01530;
    localparam vec_t VECS [10] = '{
        '{8'h03, LM,                 1'b1},
        '{8'h03, 56'h02050704B01531, 1'b0},
        '{8'h03, 56'h02050704221530, 1'b1},
        '{8'h04, 56'h02050704221530, 1'b0},
        '{8'h04, LM,                 1'b1},
        '{8'h7F, LM,                 1'b1},
        '{8'h7F, 56'h03050704B01530, 1'b0},
        '{8'h00, LM,                 1'b0},
        '{8'h40, 56'h02010101120000, 1'b1},
        '{8'h20, 56'h02060704B01530, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] c, input logic [7:0] d, output logic [7:0] rd);
        @(negedge clk);
        acc_en = 1'b1; cmd = c; wdata = d;
        #1 rd = rdata;
        @(negedge clk);
        acc_en = 1'b0; cmd = '0; wdata = '0;
    endtask

    task automatic pulse(input logic [55:0] lv);
        @(negedge clk);
        live = lv; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] thr [7] = '{8'h30, 8'h15, 8'hB0, 8'h04, 8'h07, 8'h05, 8'h02};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 flag", {7'd0, flag}, 8'h00);
        access(8'h95, 8'h00, r); chk("R10 cfg", r, 8'h00);
        access(8'hA5, 8'h00, r); chk("R10 year thr", r, 8'h00);

        // R2 program thresholds and read back
        for (int k = 0; k < 7; k++) access(8'(8'h19 + 2*k), thr[k], r);
        for (int k = 0; k < 7; k++) begin
            access(8'(8'h99 + 2*k), 8'h00, r);
            chk("R2 thr readback", r, thr[k]);
        end

        // R3 bit7 reads zero
        access(8'h15, 8'hFF, r);
        access(8'h95, 8'h00, r); chk("R3 cfg bit7 zero", r, 8'h7F);

        // R4/R5 vector table
        foreach (VECS[i]) begin
            access(8'h15, VECS[i].cfg, r);
            pulse(VECS[i].lv);
            chk(VECS[i].cfg == 8'h00 ? "R5 zero cfg" : "R4 masked match",
                {7'd0, flag}, {7'd0, VECS[i].exp});
        end

        // R6 match without tick does not set
        access(8'h15, 8'h03, r);
        @(negedge clk); live = LM;
        repeat (3) @(negedge clk);
        chk("R6 no tick", {7'd0, flag}, 8'h00);

        // R7 sticky, R9 minutes read
        pulse(LM);
        chk("R4 set", {7'd0, flag}, 8'h01);
        pulse(56'h02050704B01631);
        chk("R7 sticky over mismatch tick", {7'd0, flag}, 8'h01);
        access(8'h83, 8'h00, r);
        chk("R9 minutes merged", r, 8'h96);
        chk("R7 minutes read keeps flag", {7'd0, flag}, 8'h01);

        // R1 write with bit0 clear ignored entirely
        access(8'h14, 8'h00, r);
        chk("R1 ignored write keeps flag", {7'd0, flag}, 8'h01);
        access(8'h95, 8'h00, r);
        chk("R1 ignored write keeps cfg", r, 8'h03);
        chk("R8 cfg read clears", {7'd0, flag}, 8'h00);

        // R8 threshold read clears
        pulse(LM);
        chk("R4 set again", {7'd0, flag}, 8'h01);
        access(8'h9B, 8'h00, r);
        chk("R8 thr read clears", {7'd0, flag}, 8'h00);
        chk("R2 thr minutes", r, 8'h15);

        // R8 access wins over simultaneous match
        @(negedge clk);
        live = LM; tick = 1'b1; acc_en = 1'b1; cmd = 8'h99;
        @(negedge clk);
        tick = 1'b0; acc_en = 1'b0; cmd = '0;
        chk("R8 access beats match", {7'd0, flag}, 8'h00);

        // R1 RAM-space command does not touch config
        access(8'h55, 8'h7F, r);
        access(8'h95, 8'h00, r);
        chk("R1 ram space ignored", r, 8'h03);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule